// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

The block is a watchdog timer behind a single 32-bit configuration register on a plain register bus with one write strobe, write data and continuous read data. Software never sets the running state directly. It steps a two-bit key field through the code 01 and then the code 10 on two successive writes. One key field flips the timer between running and stopped. A second key field restarts the countdown. Bit 31 of the read data reports whether the timer is running and cannot be written.

While it runs, an 8-bit prescaler divides the bus clock by 256. Each time the prescaler wraps, a 24-bit counter steps down by one. A timeout of T bus cycles therefore takes the value T shifted right by 8 in the low 24 bits. When the count runs out, the block raises a one-cycle timeout pulse and a sticky expired flag. A host-side driver keeps the system alive by writing the restart key pair at regular intervals.

Top module: `seq_watchdog`

## Requirements
- R1: After reset the read data is all zeros, the timer is stopped, both key fields are disarmed, and the timeout pulse and expired flag are low.
- R2: Every write stores write data bits 23:0 as the reload value. Read data bits 23:0 return the stored reload value, and bits 30:24 always read 0.
- R3: Writes to bit 31 are ignored. Bit 31 reads 1 only while the timer runs.
- R4: A write with 01 in the enable key field (bits 25:24), followed by the next write with 10 in that field, toggles the running state on that second write.
- R5: A key field is armed only by a write of 01. The next write disarms it unless it completes the pair with 10. A write of 10 to a field that is not armed does nothing, and neither does 00 or 11.
- R6: Starting the timer loads the counter from bits 23:0 of the completing write and clears the prescaler. After N×256 running cycles from a load with N ≥ 1, the block gives exactly one timeout pulse and sets the expired flag, which stays set. A load of 0 expires at the first prescaler wrap.
- R7: A write with 01 in the service key field (bits 27:26), followed by the next write with 10 there, reloads the counter from that write's bits 23:0, clears the prescaler and clears the expired flag.
- R8: Stopping the timer clears the expired flag. While the timer is stopped, the counter and prescaler hold and no timeout occurs.
- R9: The two key fields keep separate armed states. Both may complete on the same write: a reload on that write takes priority over the counter hold that a stop would otherwise cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data: running bit 31, reload value bits 23:0 |
| timeoutPulse | output | 1 | One-cycle pulse when the countdown expires |
| expired | output | 1 | Sticky flag, set on expiry |

## Verification
The embedded assertions run on every cycle. They check that the running state changes only on a write carrying 10 in the enable field, and that other writes leave it alone. They also check that the timeout pulse lasts one cycle and only occurs with a zero count, that a stopped counter holds, that a load takes the written value, and that the expired flag stays set until a reload or a stop.

Some behaviour only the bench scenarios can show: the exact N×256-cycle distance to expiry, the way interrupted key pairs are rejected, and the independence of the two fields. To expose these, the bench compares the design against a behavioural model on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W      = 32;
  localparam int VAL_W      = 24;
  localparam int PRE_W      = 8;
  localparam int KEY_W      = 2;
  localparam int EN_KEY_LSB = 24;
  localparam int SV_KEY_LSB = 26;
  localparam int STATUS_BIT = 31;
  localparam logic [KEY_W-1:0] KEY_FIRST  = 2'b01;
  localparam logic [KEY_W-1:0] KEY_SECOND = 2'b10;

  typedef struct packed {
    logic load;   // restart countdown from written value
    logic stop;   // timer leaving the running state
  } wdogStrobe_t;
endpackage

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [KEY_W-1:0] keyIn,
  output logic             done
);
  logic armed;

  assign done = wrEn && armed && (keyIn == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else if (wrEn) armed <= (keyIn == KEY_FIRST);
  end

  AST_ARM_ONLY_BY_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (keyIn != KEY_FIRST) |=> !armed); // R5
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [KEY_W-1:0] enKey,
  input  logic [KEY_W-1:0] svKey,
  output logic             enabled,
  output wdogStrobe_t      strobe
);
  logic [1:0]       keyDone;
  logic [1:0][KEY_W-1:0] keyVal;

  assign keyVal[0] = enKey;
  assign keyVal[1] = svKey;

  for (genvar g = 0; g < 2; g++) begin : g_key
    wdog_keyseq u_key (
      .clk  (clk),
      .rstN (rstN),
      .wrEn (wrEn),
      .keyIn(keyVal[g]),
      .done (keyDone[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) enabled <= 1'b0;
    else if (keyDone[0]) enabled <= !enabled;
  end

  always_comb begin
    strobe.load = keyDone[1] || (keyDone[0] && !enabled);
    strobe.stop = keyDone[0] && enabled;
  end

  AST_TOGGLE_KEYED: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(enabled) |-> $past(wrEn) && ($past(enKey) == KEY_SECOND)); // R4
  AST_NO_STRAY_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && enKey == KEY_SECOND) |=> $stable(enabled)); // R5
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [VAL_W-1:0] wrValue,
  input  logic             enabled,
  input  wdogStrobe_t      strobe,
  output logic [VAL_W-1:0] reloadVal,
  output logic             timeoutPulse,
  output logic             expired
);
  logic [PRE_W-1:0] pre;
  logic [VAL_W-1:0] count;
  logic             wrap;

  assign wrap = &pre;

  always_ff @(posedge clk) begin
    if (!rstN) reloadVal <= '0;
    else if (wrEn) reloadVal <= wrValue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pre          <= '0;
      count        <= '0;
      timeoutPulse <= 1'b0;
      expired      <= 1'b0;
    end else begin
      timeoutPulse <= 1'b0;
      if (strobe.load) begin
        pre     <= '0;
        count   <= wrValue;
        expired <= 1'b0;
      end else if (strobe.stop) begin
        expired <= 1'b0;
      end else if (enabled) begin
        pre <= pre + 1'b1;
        if (wrap) begin
          if (count > 1) begin
            count <= count - 1'b1;
          end else if (!expired) begin
            count        <= '0;
            timeoutPulse <= 1'b1;
            expired      <= 1'b1;
          end
        end
      end
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse); // R6
  AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> (count == '0) && expired); // R6
  AST_EXPIRED_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    expired && !strobe.load && !strobe.stop |=> expired); // R6
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (count == $past(wrValue)) && !expired); // R7
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enabled && !strobe.load |=> $stable(count) && $stable(pre) && !timeoutPulse); // R8
endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        timeoutPulse,
  output logic        expired
);
  wdogStrobe_t      strobe;
  logic             enabled;
  logic [VAL_W-1:0] reloadVal;
  logic             unusedBits;

  assign unusedBits = ^{wrData[REG_W-1:SV_KEY_LSB+KEY_W]};

  wdog_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .enKey  (wrData[EN_KEY_LSB +: KEY_W]),
    .svKey  (wrData[SV_KEY_LSB +: KEY_W]),
    .enabled(enabled),
    .strobe (strobe)
  );

  wdog_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrValue     (wrData[VAL_W-1:0]),
    .enabled     (enabled),
    .strobe      (strobe),
    .reloadVal   (reloadVal),
    .timeoutPulse(timeoutPulse),
    .expired     (expired)
  );

  always_comb begin
    rdData             = '0;
    rdData[VAL_W-1:0]  = reloadVal;
    rdData[STATUS_BIT] = enabled;
  end

  AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrData[STATUS_BIT] && !(wrData[EN_KEY_LSB +: KEY_W] == KEY_SECOND)
    |=> $stable(rdData[STATUS_BIT])); // R3
endmodule

// File: tb/seq_watchdog_tb.sv
module seq_watchdog_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        timeoutPulse;
  logic        expired;

  int    nChecks = 0;
  int    nFails  = 0;
  int    cycles  = 0;
  string curReq  = "R1";

  // behavioural reference state
  bit          mEn, mArmE, mArmS, mExp, mPulse;
  int unsigned mReload, mCnt, mPre;

  seq_watchdog u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .timeoutPulse(timeoutPulse), .expired(expired)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    bit tog, svc, wasEn;
    cycles++;
    mPulse = 0;
    if (!rstN) begin
      mEn = 0; mArmE = 0; mArmS = 0; mExp = 0;
      mReload = 0; mCnt = 0; mPre = 0;
    end else begin
      tog = 0; svc = 0; wasEn = mEn;
      if (wrEn) begin
        tog = mArmE && (wrData[25:24] == 2'b10);
        svc = mArmS && (wrData[27:26] == 2'b10);
        mArmE = (wrData[25:24] == 2'b01);
        mArmS = (wrData[27:26] == 2'b01);
        mReload = wrData[23:0];
      end
      if (tog) mEn = !mEn;
      if (svc || (tog && !wasEn)) begin
        mCnt = wrData[23:0]; mPre = 0; mExp = 0;
      end else if (tog && wasEn) begin
        mExp = 0;
      end else if (wasEn) begin
        if (mPre == 255) begin
          mPre = 0;
          if (mCnt > 1) mCnt--;
          else if (!mExp) begin mCnt = 0; mPulse = 1; mExp = 1; end
        end else mPre++;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk({curReq, " rd"}, rdData, {mEn, 7'd0, mReload[23:0]});
      chk({curReq, " pulse"}, {31'd0, timeoutPulse}, {31'd0, mPulse});
      chk({curReq, " expired"}, {31'd0, expired}, {31'd0, mExp});
    end
  end

  function automatic logic [31:0] mk(logic [1:0] sv, logic [1:0] en, logic [23:0] v);
    return {4'd0, sv, en, v};
  endfunction

  task automatic wr(logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    idle(3); rstN = 1'b1; idle(1);
    curReq = "R1";
    chk("R1 reset rd", rdData, 32'd0);
    chk("R1 reset outs", {30'd0, timeoutPulse, expired}, 32'd0);

    curReq = "R2";
    wr(mk(2'b00, 2'b00, 24'hABCDEF));
    chk("R2 readback", rdData, 32'h00ABCDEF);

    curReq = "R3";
    wr(32'hFF00_0005);
    chk("R3 bit31 ignored", rdData, 32'h0000_0005);

    curReq = "R5";
    wr(mk(2'b00, 2'b10, 24'd2));
    chk("R5 unarmed 10", {31'd0, rdData[31]}, 32'd0);
    wr(mk(2'b00, 2'b01, 24'd2)); wr(mk(2'b00, 2'b00, 24'd2)); wr(mk(2'b00, 2'b10, 24'd2));
    chk("R5 broken by 00", {31'd0, rdData[31]}, 32'd0);
    wr(mk(2'b00, 2'b01, 24'd2)); wr(mk(2'b00, 2'b11, 24'd2)); wr(mk(2'b00, 2'b10, 24'd2));
    chk("R5 broken by 11", {31'd0, rdData[31]}, 32'd0);

    curReq = "R4";
    wr(mk(2'b00, 2'b01, 24'd2)); wr(mk(2'b00, 2'b10, 24'd2));
    chk("R4 enabled", {31'd0, rdData[31]}, 32'd1);

    curReq = "R6";
    idle(490);
    chk("R6 not yet expired", {31'd0, expired}, 32'd0);
    idle(30);
    chk("R6 expired sticky", {31'd0, expired}, 32'd1);
    idle(300);
    chk("R6 still expired", {31'd0, expired}, 32'd1);

    curReq = "R7";
    wr(mk(2'b01, 2'b00, 24'd3)); wr(mk(2'b10, 2'b00, 24'd3));
    chk("R7 service clears", {31'd0, expired}, 32'd0);
    idle(700);
    chk("R7 countdown restarted", {31'd0, expired}, 32'd0);

    curReq = "R8";
    wr(mk(2'b00, 2'b01, 24'd3)); wr(mk(2'b00, 2'b10, 24'd3));
    chk("R8 disabled", {31'd0, rdData[31]}, 32'd0);
    idle(1000);
    chk("R8 no timeout while off", {31'd0, expired}, 32'd0);
    wr(mk(2'b00, 2'b01, 24'd1)); wr(mk(2'b00, 2'b10, 24'd1));
    idle(270);
    chk("R8 re-enable reloads", {31'd0, expired}, 32'd1);
    wr(mk(2'b00, 2'b01, 24'd0)); wr(mk(2'b00, 2'b10, 24'd0));
    chk("R8 stop clears expired", {31'd0, expired}, 32'd0);

    curReq = "R9";
    wr(mk(2'b01, 2'b01, 24'd4)); wr(mk(2'b10, 2'b10, 24'd4));
    chk("R9 both keys", {31'd0, rdData[31]}, 32'd1);
    wr(mk(2'b01, 2'b01, 24'd1)); wr(mk(2'b10, 2'b10, 24'd1));
    chk("R9 stop with reload", {31'd0, rdData[31]}, 32'd0);
    idle(20);

    finishRun();
  end
endmodule